// File: doc/BRIEF.md
# Receive Data-Valid Indicator Selector

This block turns three asynchronous link-quality flags from a radio receiver into one registered data-valid signal. The three flags are:

- a signal-strength-above-threshold flag,
- a data-quality-good flag,
- a clock-recovery-locked flag.

A 2-bit response-mode input picks how the flags combine. The block can always assert valid, or OR the three flags together. It can also demand lock plus either strength or quality, or pass the quality flag straight through. Downstream logic uses the result to gate data capture.

Each flag crosses into the local clock domain through a multi-flop synchronizer. An optional per-flag glitch filter can follow the synchronizer; a parameter sets its length, and length zero removes it. A 4-bit status word shows the flag levels after synchronization and filtering, together with the current output. Register decoding lives elsewhere: the mode field and status word are plain ports.

Top module: `rxv_valid_sel`

## Requirements
- R1: While the synchronous active-low reset is asserted, the output and the status word are all zero and the mode register holds the always-valid mode. On the first edge after release the output therefore goes high whatever the mode input is.
- R2: In mode 2'b00 the output is high whatever the three flags are.
- R3: In mode 2'b01 the output is high if any of strength, quality or lock is high. It is low only when all three are low.
- R4: In mode 2'b10 the output is high only when lock is high and strength or quality is high. It falls when lock falls or when both strength and quality are low.
- R5: In mode 2'b11 the output equals the quality flag.
- R6: The mode input is registered on each edge. A mode change shows at the output on the second rising edge after the new value is applied.
- R7: With the filter off and two synchronizer stages, a flag change shows at the output on the third rising edge after it is applied.
- R8: The status word layout is bit 0 = strength, bit 1 = quality, bit 2 = lock and bit 3 = data-valid output. Bits 0 to 2 hold the synchronized (and filtered) flags, which update on the second edge after an input change.
- R9: With a filter length F > 0, a flag level must stay at the synchronizer output for F consecutive cycles before it is taken. A shorter pulse never reaches the output. An accepted change reaches the output F+1 edges after it leaves the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Response mode: 00 always, 01 any, 10 locked, 11 quality |
| rssi_i | input | 1 | Signal strength above threshold (asynchronous) |
| dq_i | input | 1 | Data quality good (asynchronous) |
| lock_i | input | 1 | Clock recovery locked (asynchronous) |
| valid_o | output | 1 | Registered data-valid indicator |
| status_o | output | 4 | {valid, lock, quality, strength} |

## Verification
The bench builds two instances side by side on the same stimulus. The first uses the defaults: two synchronizer stages and the filter removed. With these, exact edge counts for mode changes and flag changes can be checked, and random mode/flag patterns can be compared against a reference function once settled. The second instance sets the filter length to 3. This makes the filter path reachable: a two-cycle quality pulse must disappear, while a held level must arrive exactly six edges after it is applied.

// File: rtl/rxv_pkg.sv
// Package: shared types for the receive data-valid selector.
// Assumes: the three link-quality flags are packed as {lock, dq, rssi}.
package rxv_pkg;

    typedef enum logic [1:0] {
        MODE_ALWAYS  = 2'b00,
        MODE_ANY     = 2'b01,
        MODE_LOCKED  = 2'b10,
        MODE_QUALITY = 2'b11
    } rxv_mode_e;

    localparam int NUM_FLAGS = 3;
    localparam int IDX_RSSI  = 0;
    localparam int IDX_DQ    = 1;
    localparam int IDX_LOCK  = 2;

endpackage

// File: rtl/rxv_sync.sv
// Module: multi-stage synchronizer for a vector of independent async bits.
// Assumes: every bit is a slow level; bits are not coherent with each other.
module rxv_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rxv_deglitch.sv
// Module: per-bit persistence filter. A bit takes a new level only after the
// input has differed from the held level for LEN consecutive cycles.
// Assumes: inputs are already synchronous. LEN = 0 gives a plain wire.
module rxv_deglitch #(
    parameter int WIDTH = 3,
    parameter int LEN   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    if (LEN == 0) begin : g_bypass
        assign q_o = d_i;
    end else begin : g_filter
        localparam int CW = $clog2(LEN + 1);
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [CW-1:0] cnt_q;
            logic          hold_q;

            // Count cycles of disagreement and accept the level at LEN.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    hold_q <= 1'b0;
                end else if (d_i[b] == hold_q) begin
                    cnt_q  <= '0;
                end else if (cnt_q == CW'(LEN - 1)) begin
                    cnt_q  <= '0;
                    hold_q <= d_i[b];
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                end
            end

            assign q_o[b] = hold_q;
        end
    end

endmodule

// File: rtl/rxv_combine.sv
// Module: combinational policy that merges the three flags under a mode.
// Assumes: flags are synchronous and packed {lock, dq, rssi}.
module rxv_combine
    import rxv_pkg::*;
(
    input  rxv_mode_e              mode_i,
    input  logic [NUM_FLAGS-1:0]   flags_i,
    output logic                   valid_o
);

    logic rssi, dq, lock;
    assign rssi = flags_i[IDX_RSSI];
    assign dq   = flags_i[IDX_DQ];
    assign lock = flags_i[IDX_LOCK];

    // Select the combining policy for the active mode.
    always_comb begin
        unique case (mode_i)
            MODE_ALWAYS:  valid_o = 1'b1;
            MODE_ANY:     valid_o = rssi | dq | lock;
            MODE_LOCKED:  valid_o = lock & (rssi | dq);
            MODE_QUALITY: valid_o = dq;
            default:      valid_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/rxv_valid_sel.sv
// Module: top of the receive data-valid selector. Synchronizes and optionally
// filters three link-quality flags, registers the mode, and registers the
// combined valid output. It also presents a status word.
// Assumes: mode_i is synchronous to clk; the flags are asynchronous.
module rxv_valid_sel
    import rxv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       rssi_i,
    input  logic       dq_i,
    input  logic       lock_i,
    output logic       valid_o,
    output logic [3:0] status_o
);

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] lvl_s;
    logic [NUM_FLAGS-1:0] lvl_f;
    rxv_mode_e            mode_q;
    logic                 valid_d;

    assign raw_flags = {lock_i, dq_i, rssi_i};

    rxv_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (lvl_s)
    );

    rxv_deglitch #(.WIDTH(NUM_FLAGS), .LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (lvl_s),
        .q_o   (lvl_f)
    );

    // Register the mode field; reset selects the always-valid mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_ALWAYS;
        else        mode_q <= rxv_mode_e'(mode_i);
    end

    rxv_combine u_comb (
        .mode_i  (mode_q),
        .flags_i (lvl_f),
        .valid_o (valid_d)
    );

    // Register the combined indicator; reset forces it low.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_d;
    end

    assign status_o = {valid_o, lvl_f};

endmodule

// File: rtl/rxv_valid_sel_chk.sv
// Module: assertion checker bound to the selector top.
// Assumes: lvl is the filtered flag vector {lock, dq, rssi}.
module rxv_valid_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_q,
    input logic [2:0] lvl,
    input logic       valid_o
);

    // R1: an edge taken in reset leaves the output low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

    // R2: always-valid mode yields a high output
    a_r2_always_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q == 2'b00) |=> valid_o);

    // R3: any-flag mode is the OR of the flags
    a_r3_any_or: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q == 2'b01) |=> (valid_o == (|$past(lvl))));

    // R4: locked mode needs lock and strength-or-quality
    a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q == 2'b10) |=>
            (valid_o == ($past(lvl[2]) && ($past(lvl[0]) || $past(lvl[1])))));

    // R5: quality mode follows the quality flag
    a_r5_quality: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q == 2'b11) |=> (valid_o == $past(lvl[1])));

endmodule

bind rxv_valid_sel rxv_valid_sel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .lvl     (lvl_f),
    .valid_o (valid_o)
);

// File: tb/rxv_valid_sel_tb.sv
`timescale 1ns/1ps
module rxv_valid_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b11;
    logic       rssi_i = 1'b0, dq_i = 1'b0, lock_i = 1'b0;
    logic       valid_o, valid_f;
    logic [3:0] status_o, status_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxv_valid_sel u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rssi_i(rssi_i), .dq_i(dq_i), .lock_i(lock_i),
        .valid_o(valid_o), .status_o(status_o)
    );

    rxv_valid_sel #(.SYNC_STAGES(2), .FILT_LEN(3)) u_dut_filt (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rssi_i(rssi_i), .dq_i(dq_i), .lock_i(lock_i),
        .valid_o(valid_f), .status_o(status_f)
    );

    function automatic logic model(logic [1:0] m, logic r, logic d, logic l);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return r | d | l;
            2'b10:   return l & (r | d);
            default: return d;
        endcase
    endfunction

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7341);
        tick(3);
        // R1: reset state
        chk("R1 valid in reset", {3'b0, valid_o}, 4'h0);
        chk("R1 status in reset", status_o, 4'h0);
        rst_n = 1'b1;                      // mode_i = quality, dq = 0
        tick(1);
        chk("R1 default mode after release", {3'b0, valid_o}, 4'h1);
        tick(1);
        chk("R6 quality mode taken on second edge", {3'b0, valid_o}, 4'h0);

        // R7 / R8: latency of a quality flag rise in quality mode
        dq_i = 1'b1;
        tick(2);
        chk("R7 no change after two edges", {3'b0, valid_o}, 4'h0);
        chk("R8 status dq bit after two edges", status_o, 4'b0010);
        tick(1);
        chk("R7 change on third edge", {3'b0, valid_o}, 4'h1);
        chk("R8 status valid bit", status_o, 4'b1010);

        // R6: mode change latency, quality -> locked (lock low so result 0)
        mode_i = 2'b10;
        tick(1);
        chk("R6 old mode still after one edge", {3'b0, valid_o}, 4'h1);
        tick(1);
        chk("R6 locked mode after two edges", {3'b0, valid_o}, 4'h0);

        // R4: lock drop ends validity
        lock_i = 1'b1; tick(4);
        chk("R4 lock with quality", {3'b0, valid_o}, 4'h1);
        lock_i = 1'b0; tick(4);
        chk("R4 lock drop", {3'b0, valid_o}, 4'h0);

        // R2: always mode with all flags low
        mode_i = 2'b00; dq_i = 1'b0; tick(4);
        chk("R2 all flags low", {3'b0, valid_o}, 4'h1);
        // R3: any mode all low
        mode_i = 2'b01; tick(4);
        chk("R3 all flags low", {3'b0, valid_o}, 4'h0);

        // Random patterns, settled
        for (int it = 0; it < 120; it++) begin
            logic [1:0] m;
            logic r, d, l, e;
            m = 2'($urandom_range(3));
            r = 1'($urandom_range(1));
            d = 1'($urandom_range(1));
            l = 1'($urandom_range(1));
            mode_i = m; rssi_i = r; dq_i = d; lock_i = l;
            tick(4);
            e = model(m, r, d, l);
            chk(mode_req(m), {3'b0, valid_o}, {3'b0, e});
            chk("R8 status layout", status_o, {e, l, d, r});
        end

        // R9: filter instance, quality mode
        mode_i = 2'b11; rssi_i = 1'b0; lock_i = 1'b0; dq_i = 1'b0;
        tick(12);
        chk("R9 filtered baseline", {3'b0, valid_f}, 4'h0);
        dq_i = 1'b1; tick(2); dq_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            chk("R9 short pulse suppressed", {3'b0, valid_f}, 4'h0);
        end
        dq_i = 1'b1;
        tick(5);
        chk("R9 not yet after five edges", {3'b0, valid_f}, 4'h0);
        tick(1);
        chk("R9 accepted on sixth edge", {3'b0, valid_f}, 4'h1);
        chk("R9 filtered status", status_f, 4'b1010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule